// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a memory burst. A one-cycle start pulse carries the first column of the burst, together with the burst length and the beat ordering in force at that moment. From the next clock on, the block puts out one column address per cycle. With each address it gives a valid flag, and a last flag on the final beat. The first beat is always the column supplied with the start pulse; every later beat is derived from it.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size. The beats follow one of two orders. In sequential order the low bits count upward and wrap. In interleaved order the low bits of the start column are XOR-ed with the beat number. A full-page burst walks every column, wrapping from the top column to zero, and runs until it is stopped. A stop input ends any burst at once. A new start pulse may arrive on any cycle, even in the middle of a burst, and it begins a fresh burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and while no burst is running, valid_o and last_o are 0.
- R2: One cycle after a start pulse, valid_o is 1 and col_o equals the start column given with that pulse.
- R3: With ordering code 0 (sequential), beat i of a burst of length L (L in 1,2,4,8) is at column base + ((s mod L) + i) mod L, where s is the start column and base = s - (s mod L).
- R4: With ordering code 1 (interleaved), beat i of a burst of length L is at column base + ((s mod L) XOR i).
- R5: Length codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. last_o is 1 only on the final beat. valid_o falls on the cycle after the final beat unless a new start arrives.
- R6: Length code 7 selects a full-page burst. Beat i is at column (s + i) mod 256 under either ordering code, last_o stays 0, and the burst runs until stop or restart.
- R7: A stop pulse without a start makes valid_o and last_o 0 on the next cycle. When start and stop arrive together, the start wins.
- R8: A start pulse during a burst abandons that burst. The next cycle shows the new start column as beat 0 of a new burst.
- R9: Length and ordering are sampled only with the start pulse. Changing them during a burst does not alter that burst's addresses or length.
- R10: The unused length codes 4, 5 and 6 give a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new burst |
| start_col_i | input | 8 | First column of the new burst |
| blen_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| order_i | input | 1 | Beat order: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Ends the running burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
All outputs come straight from registers. Beat 0 therefore appears one clock after the start pulse is sampled, and each later beat one clock after the one before. The end of a burst, by stop or after its last beat, shows as valid_o low one clock later. The bench changes inputs on the falling edge and reads outputs on the next falling edge, which is half a clock after the edge that updated them. It sweeps every start column under every fixed length and both orders, and compares each beat with the address formula written in the requirements.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_code_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o
);
    import bcg_pkg::*;

    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        case (code_i)
            BLEN_2:    mask_o = COL_W'(1);
            BLEN_4:    mask_o = COL_W'(3);
            BLEN_8:    mask_o = COL_W'(7);
            BLEN_PAGE: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default:   mask_o = '0;
        endcase
    end
endmodule

// File: rtl/bcg_addr_step.sv
module bcg_addr_step #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] addr_o
);
    logic [COL_W-1:0] sum_w;
    logic [COL_W-1:0] seq_w;
    logic [COL_W-1:0] ilv_w;

    always_comb begin
        sum_w  = base_i + beat_i;
        seq_w  = (base_i & ~mask_i) | (sum_w & mask_i);
        ilv_w  = base_i ^ (beat_i & mask_i);
        addr_o = ilv_i ? ilv_w : seq_w;
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_i,
    input  logic             order_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    typedef struct packed {
        logic             active;
        logic             last;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] col;
    } state_t;

    state_t           st_d, st_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] idx_nx;
    logic [COL_W-1:0] step_addr;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (blen_i),
        .mask_o (dec_mask),
        .full_o (dec_full)
    );

    assign idx_nx = st_q.idx + COL_W'(1);

    bcg_addr_step #(.COL_W(COL_W)) u_step (
        .base_i (st_q.base),
        .beat_i (idx_nx),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .addr_o (step_addr)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.mask   = dec_mask;
            st_d.full   = dec_full;
            st_d.ilv    = order_i & ~dec_full;
            st_d.base   = start_col_i;
            st_d.col    = start_col_i;
            st_d.last   = (dec_mask == '0) && !dec_full;
        end else if (stop_i) begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
        end else if (st_q.active) begin
            if (st_q.last) begin
                st_d.active = 1'b0;
                st_d.last   = 1'b0;
            end else begin
                st_d.idx  = idx_nx;
                st_d.col  = step_addr;
                st_d.last = (idx_nx == st_q.mask) && !st_q.full;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.active;
    assign last_o  = st_q.last;

    assert_last_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (!valid_o && !last_o));

    assert_drop_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    assert_block_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !stop_i)
        |=> ((col_o & ~st_q.mask) == ($past(col_o) & ~st_q.mask)));
endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       order_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .order_i(order_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int beats_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int s, input int i, input int len, input int ilv);
        int off = s % len;
        int base = s - off;
        if (ilv != 0) return base + (off ^ i);
        return base + ((off + i) % len);
    endfunction

    task automatic pulse_start(input int s, input int code, input int ord);
        start_i = 1'b1; start_col_i = 8'(s); blen_i = 3'(code); order_i = ord[0];
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_burst(input string req, input int s, input int code,
                             input int ord, input bit twiddle);
        int n = beats_of(code);
        pulse_start(s, code, ord);
        for (int i = 0; i < n; i++) begin
            chk({req, " valid"}, int'(valid_o), 1);
            chk({req, " col"}, int'(col_o), exp_col(s, i, n, ord));
            chk({req, " last"}, int'(last_o), (i == n-1) ? 1 : 0);
            if (twiddle) begin
                blen_i = 3'd7; order_i = ~order_i;
            end
            if (i < n-1) @(negedge clk);
        end
        @(negedge clk);
        chk({req, " end valid"}, int'(valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(valid_o), 0);
        chk("R1 reset last", int'(last_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle valid", int'(valid_o), 0);

        for (int code = 0; code < 4; code++)
            for (int ord = 0; ord < 2; ord++)
                for (int s = 0; s < 256; s++)
                    run_burst(ord == 0 ? "R3 R5 seq" : "R4 R5 ilv", s, code, ord, 1'b0);

        for (int code = 4; code < 7; code++)
            run_burst("R10 unused code", 77, code, 0, 1'b0);

        run_burst("R9 seq cfg change", 45, 3, 0, 1'b1);
        run_burst("R9 ilv cfg change", 203, 2, 1, 1'b1);

        for (int ord = 0; ord < 2; ord++) begin
            pulse_start(250 - ord * 100, 7, ord);
            for (int i = 0; i < 300; i++) begin
                chk("R6 page valid", int'(valid_o), 1);
                chk("R6 page col", int'(col_o), (250 - ord * 100 + i) % 256);
                chk("R6 page last", int'(last_o), 0);
                @(negedge clk);
            end
            stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
            chk("R7 page stop valid", int'(valid_o), 0);
            chk("R7 page stop last", int'(last_o), 0);
        end

        pulse_start(19, 3, 0);
        @(negedge clk);
        chk("R7 col before stop", int'(col_o), exp_col(19, 1, 8, 0));
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R7 stop valid", int'(valid_o), 0);
        @(negedge clk);
        chk("R7 stays idle", int'(valid_o), 0);

        pulse_start(100, 3, 1);
        @(negedge clk);
        stop_i = 1'b1;
        pulse_start(9, 1, 0);
        stop_i = 1'b0;
        chk("R7 start wins valid", int'(valid_o), 1);
        chk("R7 start wins col", int'(col_o), 9);
        @(negedge clk);
        chk("R7 start wins beat1", int'(col_o), 8);
        chk("R7 start wins last", int'(last_o), 1);
        @(negedge clk);
        chk("R7 start wins end", int'(valid_o), 0);

        pulse_start(60, 3, 0);
        for (int i = 0; i < 3; i++) begin
            chk("R8 old beat", int'(col_o), exp_col(60, i, 8, 0));
            if (i < 2) @(negedge clk);
        end
        pulse_start(133, 2, 1);
        for (int i = 0; i < 4; i++) begin
            chk("R8 new valid", int'(valid_o), 1);
            chk("R8 new col", int'(col_o), exp_col(133, i, 4, 1));
            chk("R8 new last", int'(last_o), (i == 3) ? 1 : 0);
            @(negedge clk);
        end
        chk("R8 new end", int'(valid_o), 0);

        pulse_start(14, 2, 0);
        @(negedge clk);
        pulse_start(14, 0, 0);
        chk("R8 restart single col", int'(col_o), 14);
        chk("R8 restart single last", int'(last_o), 1);
        @(negedge clk);
        chk("R8 restart single end", int'(valid_o), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule